// File: doc/BRIEF.md
# On-Chip XRAM Access Router

This block takes byte accesses aimed at the 64 KB external data space and decides where each one is served. A fixed-size on-chip RAM sits at the top of that space. An access whose address falls in this window, while the window is enabled, completes on chip without touching the external bus. Any other access becomes a request on the external data bus and completes when that bus acknowledges.

Software can switch the window off through an enable register. While it is off, window addresses go to the external bus. The on-chip contents are never cleared, either by toggling the enable or by a low-power period. While the low-power input is high, the block accepts no new request and writes nothing to the RAM.

Top module: `xram_router`

## Requirements
- R1: The window base is 65536 minus XRAM_BYTES. An address hits the window when it is greater than or equal to the base. With the default XRAM_BYTES of 256, 0xFF00 hits and 0xFEFF misses.
- R2: An accepted access that hits the enabled window raises req_done for the cycle after the accepting clock edge. For a read, req_rdata carries the stored byte in that cycle. ext_req stays low throughout.
- R3: An accepted access that misses the window, or any accepted access while the window is disabled, raises ext_req. ext_addr, ext_we and ext_wdata hold the request until ext_ack is sampled high. req_done follows one cycle after that, and a read returns ext_rdata as sampled with ext_ack.
- R4: After reset the window enable is 1. A pulse on en_wr loads en_wdata into the enable (1 = window on).
- R5: While lp_mode is high, no new request is accepted: neither req_done nor ext_req rises, and no RAM write occurs.
- R6: RAM contents survive a low-power period and a disable/re-enable cycle of the window.
- R7: req_done is a single-cycle pulse for each accepted access.
- R8: During and right after reset, req_done and ext_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until req_done |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address in the external data space |
| req_wdata | input | 8 | Write data |
| req_done | output | 1 | Completion pulse |
| req_rdata | output | 8 | Read data, valid with req_done |
| en_wr | input | 1 | Load strobe for the window enable |
| en_wdata | input | 1 | New window enable value |
| lp_mode | input | 1 | Low-power mode |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External write flag |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External bus acknowledge |
| ext_rdata | input | 8 | External read data |

## Verification
A wrong window decode shows as soon as the access starts. A hit seen as a miss raises ext_req in the cycle after acceptance instead of req_done, and a miss seen as a hit returns on-chip data one cycle early with no bus cycle. A lost enable value or a stray write in low-power mode only shows on a later read of the affected address, so the bench reads the same bytes back after disable, re-enable and low-power periods. A stuck controller state shows as a missing or repeated req_done pulse in the cycle after the acceptance or acknowledge edge.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef enum logic [1:0] {XS_IDLE, XS_EXT, XS_DONE} xr_state_e;

  function automatic logic [16:0] win_base(input int bytes);
    return 17'h10000 - 17'(bytes);
  endfunction

  function automatic logic win_hit(input logic [15:0] addr, input int bytes);
    return {1'b0, addr} >= win_base(bytes);
  endfunction

  function automatic logic [15:0] win_off(input logic [15:0] addr, input int bytes);
    logic [16:0] d;
    d = {1'b0, addr} - win_base(bytes);
    return d[15:0];
  endfunction
endpackage

// File: rtl/xr_decode.sv
module xr_decode #(
  parameter int XRAM_BYTES = 256,
  parameter int OFF_W = 8
) (
  input  logic [15:0]      addr,
  input  logic             en,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  import xr_pkg::*;
  logic [15:0] off_full;
  always_comb begin
    off_full = win_off(addr, XRAM_BYTES);
    off      = off_full[OFF_W-1:0];
    hit      = en && win_hit(addr, XRAM_BYTES);
  end
endmodule

// File: rtl/xr_mem.sv
module xr_mem #(
  parameter int XRAM_BYTES = 256,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] cells [XRAM_BYTES];
  always_ff @(posedge clk) begin
    if (we) cells[off] <= wdata;
    if (re) rdata <= cells[off];
  end
endmodule

// File: rtl/xr_ctrl.sv
module xr_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        hit,
  input  logic        lp_mode,
  input  logic        ext_ack,
  input  logic [7:0]  ext_rdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic        ext_req,
  output logic        ext_we,
  output logic [15:0] ext_addr,
  output logic [7:0]  ext_wdata,
  output logic        req_done,
  output logic        src_ext,
  output logic [7:0]  ext_rdata_q
);
  import xr_pkg::*;
  xr_state_e st;
  logic accept, on_fire, ex_fire, ack_fire;

  assign accept   = (st == XS_IDLE) && req_valid && !lp_mode;
  assign on_fire  = accept && hit;
  assign ex_fire  = accept && !hit;
  assign ack_fire = (st == XS_EXT) && ext_ack;
  assign mem_we   = on_fire && req_we;
  assign mem_re   = on_fire && !req_we;
  assign ext_req  = (st == XS_EXT);
  assign req_done = (st == XS_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= XS_IDLE;
      src_ext     <= 1'b0;
      ext_we      <= 1'b0;
      ext_addr    <= '0;
      ext_wdata   <= '0;
      ext_rdata_q <= '0;
    end else begin
      case (st)
        XS_IDLE: begin
          if (on_fire) begin
            st      <= XS_DONE;
            src_ext <= 1'b0;
          end else if (ex_fire) begin
            st        <= XS_EXT;
            ext_we    <= req_we;
            ext_addr  <= req_addr;
            ext_wdata <= req_wdata;
          end
        end
        XS_EXT: if (ack_fire) begin
          st          <= XS_DONE;
          src_ext     <= 1'b1;
          ext_rdata_q <= ext_rdata;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  // R2: window hit completes next cycle, no bus request
  a_r2_onchip_next: assert property (@(posedge clk) disable iff (!rst_n)
    on_fire |=> req_done && !ext_req);
  // R3: miss raises the bus request
  a_r3_miss_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire |=> ext_req && !req_done);
  // R3: request fields held while waiting
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> $stable(ext_addr) && $stable(ext_we) && $stable(ext_wdata));
  // R3: done follows acknowledge
  a_r3_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ack |=> req_done);
  // R5: idle in low power stays idle
  a_r5_lp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    lp_mode && (st == XS_IDLE) |=> !req_done && !ext_req);
  // R7: done is a pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
endmodule

// File: rtl/xram_router.sv
module xram_router #(
  parameter int XRAM_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_done,
  output logic [7:0]  req_rdata,
  input  logic        en_wr,
  input  logic        en_wdata,
  input  logic        lp_mode,
  output logic        ext_req,
  output logic        ext_we,
  output logic [15:0] ext_addr,
  output logic [7:0]  ext_wdata,
  input  logic        ext_ack,
  input  logic [7:0]  ext_rdata
);
  localparam int OFF_W = (XRAM_BYTES > 1) ? $clog2(XRAM_BYTES) : 1;

  logic en_q, hit, mem_we, mem_re, src_ext;
  logic [OFF_W-1:0] off;
  logic [7:0] mem_rdata, ext_rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b1;
    else if (en_wr) en_q <= en_wdata;
  end

  xr_decode #(.XRAM_BYTES(XRAM_BYTES), .OFF_W(OFF_W)) u_dec (
    .addr(req_addr), .en(en_q), .hit(hit), .off(off));

  xr_mem #(.XRAM_BYTES(XRAM_BYTES), .OFF_W(OFF_W)) u_mem (
    .clk(clk), .we(mem_we), .re(mem_re), .off(off),
    .wdata(req_wdata), .rdata(mem_rdata));

  xr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .hit(hit), .lp_mode(lp_mode),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .req_done(req_done), .src_ext(src_ext), .ext_rdata_q(ext_rdata_q));

  assign req_rdata = src_ext ? ext_rdata_q : mem_rdata;

  // R4: enable is on in the first cycle after reset
  a_r4_en_reset: assert property (@(posedge clk)
    !rst_n |=> en_q);
  // R5: no RAM write in low power
  a_r5_no_lp_write: assert property (@(posedge clk) disable iff (!rst_n)
    lp_mode |-> !mem_we);
endmodule

// File: tb/xram_router_tb.sv
module xram_router_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, en_wr = 0, en_wdata = 0, lp_mode = 0, ext_ack = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, ext_rdata = 0;
  logic req_done, ext_req, ext_we;
  logic [7:0] req_rdata, ext_wdata;
  logic [15:0] ext_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  xram_router u_dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bus_val(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // one access; returns read data, whether the bus was used, cycles to done
  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic used, output int lat);
    int w = 0;
    used = 0; lat = 0; rd = 0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      if (req_done) begin
        lat = i; rd = req_rdata;
        req_valid = 0; ext_ack = 0;
        break;
      end
      ext_ack = 0;
      if (ext_req) begin
        used = 1; w++;
        if (w == 1) chk(ext_addr == a && ext_we == we && ext_wdata == (we ? d : ext_wdata),
                        "R3 bus fields", ext_addr, a);
        if (w >= 2) begin ext_ack = 1; ext_rdata = bus_val(a); end
      end
    end
    @(negedge clk);
    chk(!req_done, "R7 done pulse", req_done, 0);
  endtask

  // we, addr, wdata, expected rdata, expected bus use
  localparam logic [33:0] VEC [9] = '{
    {1'b1, 16'hFF00, 8'h11, 8'h00, 1'b0},
    {1'b1, 16'hFFFF, 8'h22, 8'h00, 1'b0},
    {1'b0, 16'hFF00, 8'h00, 8'h11, 1'b0},
    {1'b0, 16'hFFFF, 8'h00, 8'h22, 1'b0},
    {1'b0, 16'hFEFF, 8'h00, 8'hA5, 1'b1},
    {1'b1, 16'h1234, 8'h33, 8'h00, 1'b1},
    {1'b0, 16'h0010, 8'h00, 8'h4A, 1'b1},
    {1'b1, 16'hFF80, 8'h44, 8'h00, 1'b0},
    {1'b0, 16'hFF80, 8'h00, 8'h44, 1'b0}
  };

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd; logic used; int lat; logic seen;
    repeat (3) @(negedge clk);
    chk(!req_done && !ext_req, "R8 reset outputs", {req_done, ext_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!req_done && !ext_req, "R8 after reset", {req_done, ext_req}, 0);

    // R1 R2 R3 R4: table walk (window on from reset)
    for (int k = 0; k < 9; k++) begin
      access(VEC[k][33], VEC[k][32:17], VEC[k][16:9], rd, used, lat);
      chk(used == VEC[k][0], "R1 route", used, VEC[k][0]);
      if (!VEC[k][33]) chk(rd == VEC[k][8:1], "R2/R3 rdata", rd, VEC[k][8:1]);
      if (!VEC[k][0]) chk(lat == 1, "R2 latency", lat, 1);
      else chk(lat == 3, "R3 latency", lat, 3);
    end

    // R4: disable, window address goes to bus
    @(negedge clk); en_wr = 1; en_wdata = 0;
    @(negedge clk); en_wr = 0;
    access(0, 16'hFF00, 0, rd, used, lat);
    chk(used && rd == 8'h5A, "R4 disabled read via bus", rd, 8'h5A);
    access(1, 16'hFF00, 8'h99, rd, used, lat);
    chk(used, "R4 disabled write via bus", used, 1);
    @(negedge clk); en_wr = 1; en_wdata = 1;
    @(negedge clk); en_wr = 0;
    access(0, 16'hFF00, 0, rd, used, lat);
    chk(!used && rd == 8'h11, "R6 kept over disable", rd, 8'h11);

    // R5: low power blocks a write
    @(negedge clk); lp_mode = 1;
    req_valid = 1; req_we = 1; req_addr = 16'hFF80; req_wdata = 8'h77;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (req_done || ext_req) seen = 1;
    end
    chk(!seen, "R5 no accept in low power", seen, 0);
    req_valid = 0;
    @(negedge clk); lp_mode = 0;
    access(0, 16'hFF80, 0, rd, used, lat);
    chk(!used && rd == 8'h44, "R6 kept over low power / R5 no write", rd, 8'h44);
    access(0, 16'hFFFF, 0, rd, used, lat);
    chk(rd == 8'h22, "R6 top byte", rd, 8'h22);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule